// File: doc/BRIEF.md
# Diagnostic Sequencing and Fault-Safe State Controller

This controller takes a sensor front end from power-on to live measurement, based on the results of its built-in checks. After power-on reset it runs two diagnostic phases in order. First come the reset-time checks, then the initialization checks. Each phase ends on a completion strobe from its own check group. Only when both phases pass does the controller enter normal operation. In normal operation it enables the measurement outputs and keeps the excitation oscillator running. Each check reaches the controller as one pass/fail bit. The bits are grouped into four classes: reset-time, initialization, run-time group A and run-time group B.

Any failing check that is relevant to the current phase sends the controller to a safe state. The oscillator driver is turned off and the outputs are tri-stated. A separate critical qualifier picks which safe state is used. The fault state clears by itself once no check reports a failure, and the controller then re-runs the initialization phase. The disabled state is latched and only a power-on reset leaves it. All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `safety_seq_ctrl`

## Requirements
- R1: While `por_n` is low, at every clock edge `state_code` becomes 0 (RESET), and `osc_drv_en` and `out_en` become 0.
- R2: `state_code` is registered and changes only on a clock edge, one cycle after the inputs that cause the change. The encodings are RESET=0, INIT=1, NORMAL=2, FAULT=3, DISABLED=4.
- R3: In RESET, with no reset-class failure, `rst_chk_done` high moves the state to INIT. Without the strobe the state stays in RESET.
- R4: In INIT, with no initialization-class failure, `init_chk_done` high moves the state to NORMAL. NORMAL is entered from no other state.
- R5: `out_en` is 1 exactly when the state is NORMAL. `osc_drv_en` is 1 exactly when the state is INIT or NORMAL.
- R6: A failure bit in the class of the current phase sends the state to FAULT on the next edge when `fault_critical` is low. The phase classes are: reset class in RESET, initialization class in INIT, and run-time group A or B in NORMAL. A failure wins over a simultaneous done strobe.
- R7: When a phase-relevant failure arrives together with `fault_critical` high, the next state is DISABLED instead of FAULT.
- R8: Failure bits and done strobes of a class outside its phase have no effect. Examples are run-time bits in RESET or INIT, reset or initialization bits in NORMAL, and done strobes in NORMAL.
- R9: In FAULT, the state holds while any failure bit of any class is high. When all failure bits are low, the state moves to INIT.
- R10: In FAULT, any failure bit together with `fault_critical` high moves the state to DISABLED.
- R11: DISABLED holds with both enables low, whatever the inputs, until `por_n` goes low.
- R12: `fault_critical` high with no failure bit set has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_chk_fail | input | N_RST | Reset-time check failures, one bit per check |
| rst_chk_done | input | 1 | Reset-time check group finished |
| init_chk_fail | input | N_INIT | Initialization check failures |
| init_chk_done | input | 1 | Initialization check group finished |
| run_a_fail | input | N_RUN_A | Run-time group A check failures |
| run_b_fail | input | N_RUN_B | Run-time group B check failures |
| fault_critical | input | 1 | Marks the present failure as critical |
| osc_drv_en | output | 1 | Oscillator driver enable |
| out_en | output | 1 | Measurement output enable; 0 tri-states the outputs |
| state_code | output | 3 | Registered state code |

## Verification
The bench builds the controller with four reset-time checks, three initialization checks, three group-A checks and two group-B checks. These widths are small enough that the random stimulus often raises single bits and combinations in every class. Each class therefore reaches each phase, both in and out of its own phase. The narrow fault vectors also make all-clear cycles frequent, so the exit from FAULT back through INIT happens often. Short power-on pulses are mixed in, so DISABLED is left and re-entered many times within one run.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET    = 3'd0,
    ST_INIT     = 3'd1,
    ST_NORMAL   = 3'd2,
    ST_FAULT    = 3'd3,
    ST_DISABLED = 3'd4
  } fm_state_e;
endpackage

// File: rtl/fm_fault_merge.sv
module fm_fault_merge #(
  parameter int W = 4
) (
  input  logic [W-1:0] flags,
  output logic         hit
);
  assign hit = |flags;
endmodule

// File: rtl/fm_state_seq.sv
module fm_state_seq
  import fm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      rst_hit,
  input  logic      init_hit,
  input  logic      run_hit,
  input  logic      rst_done,
  input  logic      init_done,
  input  logic      crit,
  output fm_state_e state_q,
  output fm_state_e state_d
);
  logic any_hit;
  fm_state_e safe_st;

  assign any_hit = rst_hit | init_hit | run_hit;
  assign safe_st = crit ? ST_DISABLED : ST_FAULT;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: begin
        if (rst_hit)       state_d = safe_st;
        else if (rst_done) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (init_hit)       state_d = safe_st;
        else if (init_done) state_d = ST_NORMAL;
      end
      ST_NORMAL: begin
        if (run_hit) state_d = safe_st;
      end
      ST_FAULT: begin
        if (!any_hit)  state_d = ST_INIT;
        else if (crit) state_d = ST_DISABLED;
      end
      ST_DISABLED: state_d = ST_DISABLED;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assert_disabled_latched_R11: assert property (@(posedge clk) disable iff (!por_n)
    state_q == ST_DISABLED |=> state_q == ST_DISABLED);

  assert_normal_via_init_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(state_q == ST_NORMAL) |-> $past(state_q) == ST_INIT);

  assert_run_fault_R6: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_NORMAL && run_hit && !crit) |=> state_q == ST_FAULT);

  assert_run_critical_R7: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_NORMAL && run_hit && crit) |=> state_q == ST_DISABLED);

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_FAULT && !any_hit) |=> state_q == ST_INIT);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_FAULT && any_hit && !crit) |=> state_q == ST_FAULT);

  assert_fault_escalate_R10: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_FAULT && any_hit && crit) |=> state_q == ST_DISABLED);

  assert_crit_alone_R12: assert property (@(posedge clk) disable iff (!por_n)
    (!any_hit && state_q != ST_FAULT && !rst_done && !init_done) |=> $stable(state_q));
endmodule

// File: rtl/fm_out_ctrl.sv
module fm_out_ctrl
  import fm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  fm_state_e state_d,
  output logic      osc_en_q,
  output logic      out_en_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      osc_en_q <= 1'b0;
      out_en_q <= 1'b0;
    end else begin
      osc_en_q <= (state_d == ST_INIT) || (state_d == ST_NORMAL);
      out_en_q <= (state_d == ST_NORMAL);
    end
  end

  assert_out_needs_osc_R5: assert property (@(posedge clk) disable iff (!por_n)
    out_en_q |-> osc_en_q);
endmodule

// File: rtl/safety_seq_ctrl.sv
module safety_seq_ctrl
  import fm_pkg::*;
#(
  parameter int N_RST   = 12,
  parameter int N_INIT  = 6,
  parameter int N_RUN_A = 5,
  parameter int N_RUN_B = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_RST-1:0]   rst_chk_fail,
  input  logic               rst_chk_done,
  input  logic [N_INIT-1:0]  init_chk_fail,
  input  logic               init_chk_done,
  input  logic [N_RUN_A-1:0] run_a_fail,
  input  logic [N_RUN_B-1:0] run_b_fail,
  input  logic               fault_critical,
  output logic               osc_drv_en,
  output logic               out_en,
  output logic [STATE_W-1:0] state_code
);
  logic rst_hit, init_hit, run_a_hit, run_b_hit, run_hit;
  fm_state_e state_q, state_d;

  fm_fault_merge #(.W(N_RST))   u_rst_merge  (.flags(rst_chk_fail),  .hit(rst_hit));
  fm_fault_merge #(.W(N_INIT))  u_init_merge (.flags(init_chk_fail), .hit(init_hit));
  fm_fault_merge #(.W(N_RUN_A)) u_runa_merge (.flags(run_a_fail),    .hit(run_a_hit));
  fm_fault_merge #(.W(N_RUN_B)) u_runb_merge (.flags(run_b_fail),    .hit(run_b_hit));

  assign run_hit = run_a_hit | run_b_hit;

  fm_state_seq u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .rst_hit   (rst_hit),
    .init_hit  (init_hit),
    .run_hit   (run_hit),
    .rst_done  (rst_chk_done),
    .init_done (init_chk_done),
    .crit      (fault_critical),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  fm_out_ctrl u_out (
    .clk      (clk),
    .por_n    (por_n),
    .state_d  (state_d),
    .osc_en_q (osc_drv_en),
    .out_en_q (out_en)
  );

  assign state_code = state_q;

  assert_out_en_match_R5: assert property (@(posedge clk) disable iff (!por_n)
    out_en == (state_q == ST_NORMAL));

  assert_osc_match_R5: assert property (@(posedge clk) disable iff (!por_n)
    osc_drv_en == (state_q == ST_INIT || state_q == ST_NORMAL));

  assert_safe_outputs_R11: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_DISABLED || state_q == ST_FAULT) |-> (!out_en && !osc_drv_en));
endmodule

// File: tb/safety_seq_ctrl_tb_top.sv
module safety_seq_ctrl_tb_top;
  localparam int NR = 4, NI = 3, NA = 3, NB = 2;
  localparam logic [2:0] S_RST = 3'd0, S_INI = 3'd1, S_NRM = 3'd2, S_FLT = 3'd3, S_DIS = 3'd4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [NR-1:0] rf = '0;
  logic [NI-1:0] inf = '0;
  logic [NA-1:0] raf = '0;
  logic [NB-1:0] rbf = '0;
  logic rd = 1'b0, idn = 1'b0, cr = 1'b0;
  logic osc, oen;
  logic [2:0] st;
  logic [2:0] exp_st = S_RST;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  safety_seq_ctrl #(.N_RST(NR), .N_INIT(NI), .N_RUN_A(NA), .N_RUN_B(NB)) dut_i (
    .clk(clk), .por_n(por_n), .rst_chk_fail(rf), .rst_chk_done(rd),
    .init_chk_fail(inf), .init_chk_done(idn), .run_a_fail(raf), .run_b_fail(rbf),
    .fault_critical(cr), .osc_drv_en(osc), .out_en(oen), .state_code(st));

  function automatic logic [2:0] model(logic [2:0] s);
    logic [2:0] safe = cr ? S_DIS : S_FLT;
    if (!por_n) return S_RST;
    case (s)
      S_RST: return (|rf) ? safe : (rd ? S_INI : S_RST);
      S_INI: return (|inf) ? safe : (idn ? S_NRM : S_INI);
      S_NRM: return (|raf || |rbf) ? safe : S_NRM;
      S_FLT: return (|rf || |inf || |raf || |rbf) ? (cr ? S_DIS : S_FLT) : S_INI;
      default: return S_DIS;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // one cycle: inputs already driven; model next state, sample after the edge
  task automatic tick(input string tag);
    exp_st = model(exp_st);
    @(posedge clk); #1;
    chk(st == exp_st, {tag, " state R2"}, st, exp_st);
    chk(oen == (exp_st == S_NRM), "R5 out_en", oen, exp_st == S_NRM);
    chk(osc == (exp_st == S_INI || exp_st == S_NRM), "R5 osc_drv_en", osc,
        exp_st == S_INI || exp_st == S_NRM);
  endtask

  task automatic clr();
    rf = '0; inf = '0; raf = '0; rbf = '0; rd = 0; idn = 0; cr = 0; por_n = 1;
  endtask

  task automatic expect_st(input logic [2:0] e, input string tag);
    chk(st == e, tag, st, e);
  endtask

  task automatic power_on();
    clr(); por_n = 0; tick("R1"); expect_st(S_RST, "R1 reset code");
    chk(!oen && !osc, "R1 enables low", {oen, osc}, 0);
    por_n = 1;
  endtask

  task automatic to_normal();
    power_on(); rd = 1; tick("R3"); rd = 0; idn = 1; tick("R4"); idn = 0;
    expect_st(S_NRM, "R4 reached normal");
  endtask

  initial begin
    void'($urandom(32'h1357_9BDF));
    @(posedge clk); #1;
    power_on(); tick("R1");
    // RESET phase
    tick("R3"); expect_st(S_RST, "R3 wait for strobe");
    cr = 1; tick("R12"); expect_st(S_RST, "R12 critical alone");
    cr = 0; raf = 3'b010; rbf = 2'b01; inf = 3'b100; tick("R8");
    expect_st(S_RST, "R8 out-of-phase in RESET");
    clr(); rd = 1; tick("R3"); expect_st(S_INI, "R3 to INIT");
    chk(osc && !oen, "R5 INIT enables", {osc, oen}, 2);
    // INIT failure beats done
    rd = 0; idn = 1; inf = 3'b001; tick("R6"); expect_st(S_FLT, "R6 init fault");
    chk(!osc && !oen, "R5 FAULT enables", {osc, oen}, 0);
    idn = 0; inf = '0; raf = 3'b100; tick("R9"); expect_st(S_FLT, "R9 hold any class");
    raf = '0; tick("R9"); expect_st(S_INI, "R9 clear to INIT");
    idn = 1; tick("R4"); expect_st(S_NRM, "R4 to NORMAL");
    chk(oen && osc, "R5 NORMAL enables", {oen, osc}, 3);
    // NORMAL ignores earlier classes and strobes
    idn = 1; rd = 1; rf = 4'b1000; inf = 3'b010; tick("R8");
    expect_st(S_NRM, "R8 out-of-phase in NORMAL");
    clr(); cr = 1; tick("R12"); expect_st(S_NRM, "R12 critical alone in NORMAL");
    cr = 0; rbf = 2'b10; tick("R6"); expect_st(S_FLT, "R6 run B fault");
    cr = 1; tick("R10"); expect_st(S_DIS, "R10 escalate");
    rf = '1; inf = '1; raf = '1; rbf = '1; rd = 1; idn = 1;
    for (int i = 0; i < 3; i++) begin tick("R11"); expect_st(S_DIS, "R11 latched"); end
    clr(); for (int i = 0; i < 2; i++) begin tick("R11"); expect_st(S_DIS, "R11 clear inputs"); end
    // critical in NORMAL and in RESET
    to_normal(); raf = 3'b001; cr = 1; tick("R7"); expect_st(S_DIS, "R7 run A critical");
    power_on(); rf = 4'b0100; cr = 1; rd = 1; tick("R7"); expect_st(S_DIS, "R7 reset critical");
    power_on(); rf = 4'b0001; rd = 1; tick("R6"); expect_st(S_FLT, "R6 reset fault");
    clr(); tick("R9"); expect_st(S_INI, "R9 exit");
    // constrained random
    for (int c = 0; c < 4000; c++) begin
      por_n = ($urandom_range(199) != 0);
      for (int b = 0; b < NR; b++) rf[b] = ($urandom_range(39) == 0);
      for (int b = 0; b < NI; b++) inf[b] = ($urandom_range(39) == 0);
      for (int b = 0; b < NA; b++) raf[b] = ($urandom_range(39) == 0);
      for (int b = 0; b < NB; b++) rbf[b] = ($urandom_range(59) == 0);
      rd = ($urandom_range(3) == 0);
      idn = ($urandom_range(3) == 0);
      cr = ($urandom_range(5) == 0);
      tick("R6/R7/R9/R10/R11 random");
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule